// File: doc/BRIEF.md
# Staged Thermal Protection Comparator

This block turns a set of four raw temperature readings into a single protection temperature and compares it against three escalating limits. Each time the sensor front end presents a fresh set of readings with a valid strobe, the block forms the protection temperature in one of three ways. It can take the truncated mean of the four readings, the hottest reading, or one reading picked by an index. That value is then compared against three stage thresholds.

Each stage that is reached raises a sticky status flag. Software clears a flag by pulsing a write-one-to-clear input. The third, highest stage is intended to hold the hardware shutdown temperature. Once its flag is raised, a shutdown request is latched one cycle later and held until the block is reset, so clearing the status bit cannot withdraw a shutdown that is under way.

Top module: `thermal_stage_guard`

## Requirements
- R1: After a synchronous active-low reset, all three stage flags and the shutdown request read 0.
- R2: With `cfg_mode` = 2'b00, the protection temperature is the sum of the four readings divided by four with truncation (for example 100, 101, 102 and 104 give 101).
- R3: With `cfg_mode` = 2'b01, the protection temperature is the largest of the four readings.
- R4: With `cfg_mode` = 2'b10, the protection temperature is the reading in slot `cfg_sel` (slot k occupies bits 15k+14:15k of `sample_data`).
- R5: The reserved code `cfg_mode` = 2'b11 forms the protection temperature exactly as the maximum code does.
- R6: A stage flag (bit 0 = stage 1, bit 1 = stage 2, bit 2 = stage 3 of `stage_flag`) sets when the protection temperature is greater than or equal to that stage's threshold. It is visible two clock edges after the edge that captures `sample_vld`. A value one below the threshold does not set it.
- R7: A stage whose threshold (slot k of `stage_thresh` = stage k+1, bits 15k+14:15k) is zero never sets, whatever the readings.
- R8: A set stage flag holds until a 1 is applied on its bit of `stage_clr`, which clears it at the next edge. If a set condition and a clear arrive on the same edge, the flag stays set.
- R9: `shutdown_req` rises on the edge after the stage 3 flag sets. It remains 1 after that flag is cleared, until reset.
- R10: Readings presented while `sample_vld` is 0 are ignored and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | Strobe marking a fresh set of readings |
| sample_data | input | 60 | Four 15-bit raw readings, slot k at bits 15k+14:15k |
| cfg_mode | input | 2 | Strategy: 00 mean, 01 max, 10 selected, 11 treated as max |
| cfg_sel | input | 2 | Index of the reading used by strategy 10 |
| stage_thresh | input | 45 | Three 15-bit thresholds, stage k+1 at bits 15k+14:15k; zero disables |
| stage_clr | input | 3 | Write-one-to-clear pulses for the stage flags |
| stage_flag | output | 3 | Sticky stage flags, bit 0 = stage 1 |
| shutdown_req | output | 1 | Latched shutdown request from stage 3 |

## Verification
The bench builds the block with its default parameters: 15-bit readings, four sensors and three stages. At that size the full raw range is in use, so a set of all-maximum readings exercises the widest sum in the mean path. The two-bit select index also reaches every sensor slot. Each strategy is checked by placing one threshold exactly on the predicted protection temperature and the next one a single count above it, which separates the strategies from one another. The tests also cover a clear that collides with a set and a clear of stage 3 made after shutdown has latched.

// File: rtl/tsg_pkg.sv
// Shared types for the staged thermal protection comparator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tsg_pkg;

    // Strategy codes for forming the protection temperature.
    typedef enum logic [1:0] {
        MODE_MEAN = 2'b00,
        MODE_MAX  = 2'b01,
        MODE_ONE  = 2'b10,
        MODE_RSVD = 2'b11
    } prot_mode_e;

endpackage

// File: rtl/tsg_combiner.sv
// Forms one protection temperature from NUM_SENS raw readings and
// registers it together with a valid bit.
// Assumes NUM_SENS is a power of two so that the mean is a plain shift
// and every select index names a real sensor.
module tsg_combiner
    import tsg_pkg::*;
#(
    parameter int TEMP_W   = 15,
    parameter int NUM_SENS = 4,
    localparam int SEL_W   = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1,
    localparam int SUM_W   = TEMP_W + SEL_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_vld,
    input  logic [NUM_SENS*TEMP_W-1:0]   sample_data,
    input  logic [1:0]                   mode,
    input  logic [SEL_W-1:0]             sel,
    output logic                         prot_vld,
    output logic [TEMP_W-1:0]            prot_temp
);

    logic [TEMP_W-1:0] rd [NUM_SENS];
    logic [SUM_W-1:0]  sum_c;
    logic [SUM_W-1:0]  sum_shr;
    logic [TEMP_W-1:0] mean_c;
    logic [TEMP_W-1:0] max_c;
    logic [TEMP_W-1:0] one_c;
    logic [TEMP_W-1:0] pick_c;
    prot_mode_e        mode_e;

    // Split the packed input bus into one reading per sensor slot.
    for (genvar g = 0; g < NUM_SENS; g++) begin : g_split
        assign rd[g] = sample_data[g*TEMP_W +: TEMP_W];
    end

    // Sum all readings at full width and truncate-divide by the count.
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < NUM_SENS; i++) begin
            sum_c = sum_c + SUM_W'(rd[i]);
        end
        sum_shr = sum_c >> SEL_W;
        mean_c  = sum_shr[TEMP_W-1:0];
    end

    // Find the hottest reading.
    always_comb begin
        max_c = rd[0];
        for (int i = 1; i < NUM_SENS; i++) begin
            if (rd[i] > max_c) begin
                max_c = rd[i];
            end
        end
    end

    // Pick the indexed reading.
    assign one_c = rd[sel];

    // Choose the strategy; the reserved code falls back to the maximum.
    always_comb begin
        mode_e = prot_mode_e'(mode);
        case (mode_e)
            MODE_MEAN: pick_c = mean_c;
            MODE_ONE:  pick_c = one_c;
            default:   pick_c = max_c;
        endcase
    end

    // Register the protection temperature whenever a sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_vld  <= 1'b0;
            prot_temp <= '0;
        end else begin
            prot_vld <= sample_vld;
            if (sample_vld) begin
                prot_temp <= pick_c;
            end
        end
    end

    // The maximum strategies never yield a value below any reading.
    for (genvar g = 0; g < NUM_SENS; g++) begin : g_chk
        AST_MAX_COVERS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_vld && mode[0] && (mode[1] || 1'b1) && (mode == 2'b01 || mode == 2'b11))
            |=> (prot_temp >= $past(rd[g]))); // R3
    end

    // A mean is never above the largest reading.
    AST_MEAN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && mode == 2'b00) |=> (prot_temp <= $past(max_c))); // R2

    // No strobe, no new protection value.
    AST_NO_STROBE_NO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> !prot_vld); // R10

endmodule

// File: rtl/tsg_stage_flag.sv
// One protection stage: compares the registered protection temperature
// with a threshold and keeps a sticky write-one-to-clear flag.
// Assumes a zero threshold means the stage is switched off and that a
// set on the same edge as a clear wins, so no event is lost.
module tsg_stage_flag #(
    parameter int TEMP_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_vld,
    input  logic [TEMP_W-1:0] prot_temp,
    input  logic [TEMP_W-1:0] thresh,
    input  logic              clr,
    output logic              flag
);

    logic armed;
    logic reach;
    logic flag_q;

    // Stage is live only with a non-zero threshold.
    assign armed = (thresh != '0);

    // Trip on a fresh value at or above the threshold.
    assign reach = prot_vld && armed && (prot_temp >= thresh);

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (reach) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

    AST_TRIP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_vld && thresh != '0 && prot_temp >= thresh) |=> flag); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R8

    AST_ZERO_THRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && thresh == '0) |=> !flag); // R7

    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !prot_vld) |=> !flag); // R10

endmodule

// File: rtl/tsg_shutdown_latch.sv
// Latches a shutdown request one cycle after the top stage trips and
// holds it until reset, independent of the stage flag being cleared.
// Assumes reset is the only way to withdraw a shutdown.
module tsg_shutdown_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    output logic req
);

    logic req_q;

    // Set once on trip; only reset releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (trip) begin
            req_q <= 1'b1;
        end
    end

    assign req = req_q;

    AST_SHUTDOWN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> req); // R9

    AST_SHUTDOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> req); // R9

endmodule

// File: rtl/thermal_stage_guard.sv
// Top of the staged thermal protection comparator. Combines the sensor
// readings, drives NUM_STAGES stage comparators and latches a shutdown
// request from the highest stage.
// Assumes configuration is stable while a sample travels through the
// two pipeline registers.
module thermal_stage_guard
    import tsg_pkg::*;
#(
    parameter int TEMP_W     = 15,
    parameter int NUM_SENS   = 4,
    parameter int NUM_STAGES = 3,
    localparam int SEL_W     = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample_vld,
    input  logic [NUM_SENS*TEMP_W-1:0]    sample_data,
    input  logic [1:0]                    cfg_mode,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [NUM_STAGES*TEMP_W-1:0]  stage_thresh,
    input  logic [NUM_STAGES-1:0]         stage_clr,
    output logic [NUM_STAGES-1:0]         stage_flag,
    output logic                          shutdown_req
);

    logic              prot_vld;
    logic [TEMP_W-1:0] prot_temp;

    // Protection temperature path.
    tsg_combiner #(
        .TEMP_W   (TEMP_W),
        .NUM_SENS (NUM_SENS)
    ) u_comb (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_vld  (sample_vld),
        .sample_data (sample_data),
        .mode        (cfg_mode),
        .sel         (cfg_sel),
        .prot_vld    (prot_vld),
        .prot_temp   (prot_temp)
    );

    // One comparator and sticky flag per stage.
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        tsg_stage_flag #(
            .TEMP_W (TEMP_W)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .prot_vld  (prot_vld),
            .prot_temp (prot_temp),
            .thresh    (stage_thresh[s*TEMP_W +: TEMP_W]),
            .clr       (stage_clr[s]),
            .flag      (stage_flag[s])
        );
    end

    // Shutdown request from the highest stage.
    tsg_shutdown_latch u_sd (
        .clk   (clk),
        .rst_n (rst_n),
        .trip  (stage_flag[NUM_STAGES-1]),
        .req   (shutdown_req)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (stage_flag == '0 && !shutdown_req)); // R1

endmodule

// File: tb/thermal_stage_guard_test.sv
`timescale 1ns/1ps
module thermal_stage_guard_test;

    localparam int TW = 15;
    localparam int NS = 4;
    localparam int NG = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_vld = 1'b0;
    logic [NS*TW-1:0]  sample_data = '0;
    logic [1:0]        cfg_mode = 2'b00;
    logic [1:0]        cfg_sel = 2'b00;
    logic [NG*TW-1:0]  stage_thresh = '0;
    logic [NG-1:0]     stage_clr = '0;
    logic [NG-1:0]     stage_flag;
    logic              shutdown_req;

    thermal_stage_guard uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_vld   (sample_vld),
        .sample_data  (sample_data),
        .cfg_mode     (cfg_mode),
        .cfg_sel      (cfg_sel),
        .stage_thresh (stage_thresh),
        .stage_clr    (stage_clr),
        .stage_flag   (stage_flag),
        .shutdown_req (shutdown_req)
    );

    always #4 clk = ~clk;

    typedef struct {
        int           due;
        logic [NG-1:0] flags;
        logic         sd;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   cycle = 0;
    int   total = 0;
    int   fails = 0;
    logic [NG-1:0] m_flags = '0;
    logic          m_sd = 1'b0;
    int            thr[NG];

    always @(posedge clk) cycle = cycle + 1;

    // Monitor: compare each expected item in the cycle it falls due.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cycle) begin
                exp_t e;
                e = q.pop_front();
                total = total + 1;
                if (stage_flag !== e.flags || shutdown_req !== e.sd) begin
                    fails = fails + 1;
                    $display("FAIL %s: flags=%b sd=%b expected flags=%b sd=%b",
                             e.tag, stage_flag, shutdown_req, e.flags, e.sd);
                end
            end
        end
    end

    function automatic int prot_of(int d[NS], int mode, int sel);
        int s;
        int m;
        s = 0;
        m = d[0];
        for (int i = 0; i < NS; i++) begin
            s = s + d[i];
            if (d[i] > m) m = d[i];
        end
        case (mode)
            0: return s / NS;
            2: return d[sel];
            default: return m;
        endcase
    endfunction

    task automatic set_thr(int t1, int t2, int t3);
        thr[0] = t1; thr[1] = t2; thr[2] = t3;
        @(negedge clk);
        stage_thresh = {TW'(t3), TW'(t2), TW'(t1)};
    endtask

    function automatic logic [NG-1:0] hits(int p);
        logic [NG-1:0] h;
        for (int k = 0; k < NG; k++) h[k] = (thr[k] != 0) && (p >= thr[k]);
        return h;
    endfunction

    task automatic push(int due, string tag);
        exp_t e;
        e.due = due; e.flags = m_flags; e.sd = m_sd; e.tag = tag;
        q.push_back(e);
    endtask

    // Driver: apply one sample, optionally with a clear one cycle later.
    task automatic do_sample(int d[NS], int mode, int sel, logic vld,
                             logic [NG-1:0] clr_late, string tag);
        int c;
        int p;
        @(negedge clk);
        c = cycle;
        sample_vld = vld;
        cfg_mode = mode[1:0];
        cfg_sel = sel[1:0];
        sample_data = {TW'(d[3]), TW'(d[2]), TW'(d[1]), TW'(d[0])};
        p = prot_of(d, mode, sel);
        m_flags = (m_flags & ~clr_late) | (vld ? hits(p) : '0);
        push(c + 2, tag);
        m_sd = m_sd | m_flags[NG-1];
        push(c + 3, tag);
        @(negedge clk);
        sample_vld = 1'b0;
        stage_clr = clr_late;
        @(negedge clk);
        stage_clr = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_clear(logic [NG-1:0] mask, string tag);
        int c;
        @(negedge clk);
        c = cycle;
        stage_clr = mask;
        m_flags = m_flags & ~mask;
        push(c + 1, tag);
        @(negedge clk);
        stage_clr = '0;
        @(negedge clk);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_flags = '0;
        m_sd = 1'b0;
        total = total + 1;
        if (stage_flag !== '0 || shutdown_req !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL %s: flags=%b sd=%b expected flags=000 sd=0",
                     tag, stage_flag, shutdown_req);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total = total + 1;
        fails = fails + 1;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int d[NS];
        do_reset("R1 reset state");

        // R2 mean with truncation, R6 equality sets, one above does not.
        set_thr(101, 102, 0);
        d = '{100, 101, 102, 104};
        do_sample(d, 0, 0, 1'b1, '0, "R2 R6 mean 407/4=101");
        do_clear(3'b001, "R8 clear stage 1");

        // R3 maximum.
        set_thr(500, 501, 0);
        d = '{10, 500, 20, 30};
        do_sample(d, 1, 0, 1'b1, '0, "R3 max 500");
        do_clear(3'b001, "R8 clear after max");

        // R5 reserved code acts as maximum.
        do_sample(d, 3, 0, 1'b1, '0, "R5 reserved as max");
        do_clear(3'b001, "R8 clear after reserved");

        // R4 selected sensor, two indices.
        set_thr(300, 301, 0);
        d = '{900, 50, 300, 700};
        do_sample(d, 2, 2, 1'b1, '0, "R4 select slot 2");
        do_clear(3'b001, "R8 clear after select");
        set_thr(700, 701, 0);
        do_sample(d, 2, 3, 1'b1, '0, "R4 select slot 3");
        do_clear(3'b001, "R8 clear after slot 3");

        // R6 below threshold stays clear.
        set_thr(1000, 2000, 0);
        d = '{999, 999, 999, 999};
        do_sample(d, 0, 0, 1'b1, '0, "R6 one below threshold");

        // R7 zero threshold disables stage 1, full-scale mean hits stage 2.
        set_thr(0, 32767, 0);
        d = '{32767, 32767, 32767, 32767};
        do_sample(d, 0, 0, 1'b1, '0, "R7 zero threshold, full-scale mean");
        do_clear(3'b010, "R8 clear stage 2");

        // R10 no strobe: hot readings ignored.
        set_thr(10, 10, 10);
        do_sample(d, 1, 0, 1'b0, '0, "R10 readings without strobe");

        // R8 set and clear on the same edge: set wins.
        set_thr(50, 0, 0);
        d = '{60, 60, 60, 60};
        do_sample(d, 1, 0, 1'b1, '0, "R8 first set");
        do_sample(d, 1, 0, 1'b1, 3'b001, "R8 set beats clear");
        do_clear(3'b001, "R8 clear ends");

        // R9 stage 3 trips, shutdown follows and survives the clear.
        set_thr(0, 0, 400);
        d = '{400, 400, 400, 400};
        do_sample(d, 0, 0, 1'b1, '0, "R9 stage 3 and shutdown");
        do_clear(3'b100, "R9 shutdown held after clear");
        do_reset("R1 R9 reset releases shutdown");

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule